// File: doc/BRIEF.md
# Gated Edge-Count Frequency Meter

This block measures the frequency of an external pulse signal, nominally between 0.4 and 12 MHz, by counting its rising edges over a fixed gate window. The window is timed in cycles of a slow reference crystal at 75 kHz. The crystal arrives at the block as a one-cycle tick strobe `refTick` in the fast measurement clock domain. Four window lengths are available: 75, 300, 600 and 2400 reference ticks, which are 1, 4, 8 and 32 ms.

Software first writes a configuration of a mode field and a gate select. It then issues a separate start command. The start clears the previous result and opens the gate. When the chosen number of reference ticks has passed, the gate closes and a completion flag rises. The edge count then stays readable and unchanged until the next start. The asynchronous input passes through a synchronizer before edge detection. While the chip is in a low-power or stopped state, the input is shut out by `inputOff`. During that time the window keeps running, but no edges are counted. The count saturates instead of wrapping.

Top module: `gated_freq_counter`

## Requirements
- R1: After reset, `done` is 0, `count` is 0, and the configuration holds mode 00 with gate select 00.
- R2: A cycle with `cfgWe` high stores `cfgMode` and `cfgGate`. The gate select gives a window of 75 ticks for 00, 300 for 01, 600 for 10 and 2400 for 11.
- R3: The count is `CNT_W` bits wide (20 by default). It stops at all ones and never wraps.
- R4: A start command in mode 00 clears `count` and `done` and opens the gate. `done` rises on the clock edge that samples the N-th `refTick` after the start edge, where N is the selected window length. A tick sampled on the start edge itself does not count.
- R5: Each rising edge of `sigIn` while the gate is open adds one to `count`. This holds when `sigIn` stays high for at least 2 clocks and low for at least 2 clocks.
- R6: Rising edges that reach the edge detector while `inputOff` is high are not counted, even with the gate open.
- R7: From the rise of `done` until the next accepted start, `count` does not change, whatever `sigIn` does.
- R8: A start command while the stored mode is not 00 is ignored: `done` and `count` keep their values.
- R9: A configuration write while the gate is open does not change the current window. The new gate select applies from the next start.
- R10: A start while the gate is open restarts the measurement. The count clears, and the full window is timed from the new start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgMode | input | 2 | Mode field; 00 selects frequency measurement |
| cfgGate | input | 2 | Gate-time select |
| startCmd | input | 1 | Start command, one clock |
| refTick | input | 1 | One-cycle strobe per reference crystal period |
| sigIn | input | 1 | Asynchronous signal under measurement |
| inputOff | input | 1 | High while the chip is in a low-power or stopped state |
| done | output | 1 | Count-end flag |
| count | output | CNT_W | Edge count result |

## Verification
The assertions check on every cycle that the count never wraps past all ones and moves by at most one per cycle. They also check that it freezes while the input is shut out or after the flag rises, and that a start clears it. A separate tick tally confirms that the flag rises after exactly the latched window length. Whether the count equals the number of edges actually driven, whether each gate select gives its window length, and how restarts, ignored starts and mid-window configuration writes behave can only be shown by the bench scenarios. Those scenarios compare results against their own tallies of ticks and driven pulses. The saturation case uses a second instance with a narrow counter.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;

  // Mode value that enables the frequency measurement.
  localparam logic [1:0] MODE_FREQ = 2'b00;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clrCount;  // accepted start: zero the counter
    logic gateOpen;  // measurement window is open
  } fcntStrobe_t;

endpackage

// File: rtl/fcnt_ctrl.sv
module fcnt_ctrl
  import fcnt_pkg::*;
#(
  parameter int GATE_T0 = 75,
  parameter int GATE_T1 = 300,
  parameter int GATE_T2 = 600,
  parameter int GATE_T3 = 2400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [1:0]  cfgModeIn,
  input  logic [1:0]  cfgSelIn,
  input  logic        startCmd,
  input  logic        refTick,
  output fcntStrobe_t strobe,
  output logic        done
);

  localparam int GMAX01 = (GATE_T0 > GATE_T1) ? GATE_T0 : GATE_T1;
  localparam int GMAX23 = (GATE_T2 > GATE_T3) ? GATE_T2 : GATE_T3;
  localparam int GMAX   = (GMAX01 > GMAX23) ? GMAX01 : GMAX23;
  localparam int TMR_W  = $clog2(GMAX + 1);

  logic [1:0]       modeReg;
  logic [1:0]       selReg;
  logic             running;
  logic             doneReg;
  logic [TMR_W-1:0] remain;
  logic             startOk;

  function automatic logic [TMR_W-1:0] gateLen(input logic [1:0] s);
    case (s)
      2'd0:    return TMR_W'(GATE_T0);
      2'd1:    return TMR_W'(GATE_T1);
      2'd2:    return TMR_W'(GATE_T2);
      default: return TMR_W'(GATE_T3);
    endcase
  endfunction

  assign startOk = startCmd && (modeReg == MODE_FREQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_FREQ;
      selReg  <= 2'd0;
      running <= 1'b0;
      doneReg <= 1'b0;
      remain  <= '0;
    end else begin
      if (cfgWe) begin
        modeReg <= cfgModeIn;
        selReg  <= cfgSelIn;
      end
      if (startOk) begin
        running <= 1'b1;
        doneReg <= 1'b0;
        remain  <= gateLen(selReg);
      end else if (running && refTick) begin
        remain <= remain - 1'b1;
        if (remain == TMR_W'(1)) begin
          running <= 1'b0;
          doneReg <= 1'b1;
        end
      end
    end
  end

  assign strobe.clrCount = startOk;
  assign strobe.gateOpen = running;
  assign done            = doneReg;

  // Independent tally of ticks seen inside the window, for the checks below.
  logic [TMR_W-1:0] tickSeen;
  logic [TMR_W-1:0] lenHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickSeen <= '0;
      lenHeld  <= '0;
    end else if (startOk) begin
      tickSeen <= '0;
      lenHeld  <= gateLen(selReg);
    end else if (running && refTick) begin
      tickSeen <= tickSeen + 1'b1;
    end
  end

  // R4: the flag rises only after exactly the latched number of ticks.
  p_gate_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneReg) |-> (tickSeen == lenHeld));

  // R4: flag and open gate never coexist.
  p_done_closed_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneReg |-> !running);

  // R8: a start in a non-measurement mode leaves an idle block as it was.
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && modeReg != MODE_FREQ && !running) |=> ($stable(doneReg) && !running));

  // R10: an accepted start always leaves an open gate and a cleared flag.
  p_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    startOk |=> (running && !doneReg));

endmodule

// File: rtl/fcnt_datapath.sv
module fcnt_datapath
  import fcnt_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigIn,
  input  logic             inputOff,
  input  fcntStrobe_t      strobe,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_N-1:0] syncChain;
  logic              sigPrev;
  logic              riseSeen;
  logic [CNT_W-1:0]  cntReg;

  genvar g;
  generate
    for (g = 0; g < SYNC_N; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= sigIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[g] <= 1'b0;
          else       syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) sigPrev <= 1'b0;
    else       sigPrev <= syncChain[SYNC_N-1];
  end

  assign riseSeen = syncChain[SYNC_N-1] && !sigPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg <= '0;
    end else if (strobe.clrCount) begin
      cntReg <= '0;
    end else if (strobe.gateOpen && riseSeen && !inputOff && cntReg != CNT_MAX) begin
      cntReg <= cntReg + 1'b1;
    end
  end

  assign count = cntReg;

  // R3: once at all ones, only a clear moves the counter.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cntReg == CNT_MAX && !strobe.clrCount) |=> (cntReg == CNT_MAX));

  // R5: without a clear the count grows by at most one per cycle.
  p_single_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrCount |=> (cntReg == $past(cntReg) || cntReg == $past(cntReg) + 1'b1));

  // R6: a shut-out input never changes the count.
  p_inhibit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inputOff && !strobe.clrCount) |=> $stable(cntReg));

  // R4: a clear always leaves zero.
  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCount |=> (cntReg == '0));

endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter
  import fcnt_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int SYNC_N  = 2,
  parameter int GATE_T0 = 75,
  parameter int GATE_T1 = 300,
  parameter int GATE_T2 = 600,
  parameter int GATE_T3 = 2400
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgMode,
  input  logic [1:0]       cfgGate,
  input  logic             startCmd,
  input  logic             refTick,
  input  logic             sigIn,
  input  logic             inputOff,
  output logic             done,
  output logic [CNT_W-1:0] count
);

  fcntStrobe_t strobe;

  fcnt_ctrl #(
    .GATE_T0(GATE_T0), .GATE_T1(GATE_T1), .GATE_T2(GATE_T2), .GATE_T3(GATE_T3)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgModeIn(cfgMode),
    .cfgSelIn(cfgGate), .startCmd(startCmd), .refTick(refTick),
    .strobe(strobe), .done(done)
  );

  fcnt_datapath #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_dp (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .inputOff(inputOff),
    .strobe(strobe), .count(count)
  );

  // R7: with the flag up and no start, the result holds.
  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startCmd) |=> $stable(count));

endmodule

// File: tb/sim_gated_freq_counter.sv
module sim_gated_freq_counter;

  localparam int TP = 4;  // clocks per reference tick

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgMode = 2'b00;
  logic [1:0]  cfgGate = 2'b00;
  logic        startCmd = 1'b0;
  logic        refTick = 1'b0;
  logic        sigIn = 1'b0;
  logic        inputOff = 1'b0;
  logic        done, doneS;
  logic [19:0] count;
  logic [5:0]  countS;

  int errors = 0;
  int checks = 0;
  int tickCnt = 0;
  int ticksSeen;
  int scen;
  int pulsesK;
  int midSel;

  always #4 clk = ~clk;

  gated_freq_counter u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgGate(cfgGate),
    .startCmd(startCmd), .refTick(refTick), .sigIn(sigIn), .inputOff(inputOff),
    .done(done), .count(count)
  );

  gated_freq_counter #(.CNT_W(6)) u1 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgGate(cfgGate),
    .startCmd(startCmd), .refTick(refTick), .sigIn(sigIn), .inputOff(inputOff),
    .done(doneS), .count(countS)
  );

  always @(posedge clk) begin
    if (tickCnt == TP - 1) begin
      tickCnt <= 0;
      refTick <= 1'b1;
    end else begin
      tickCnt <= tickCnt + 1;
      refTick <= 1'b0;
    end
  end

  function automatic int gateTicks(input int sel);
    case (sel)
      0: return 75;
      1: return 300;
      2: return 600;
      default: return 2400;
    endcase
  endfunction

  function automatic int satVal(input int n, input int w);
    int mx = (1 << w) - 1;
    return (n > mx) ? mx : n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int h, input int l);
    sigIn = 1'b1;
    waitClk(h);
    sigIn = 1'b0;
    waitClk(l);
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) pulse(2 + int'($urandom % 2), 2 + int'($urandom % 2));
  endtask

  task automatic writeCfg(input logic [1:0] m, input logic [1:0] g);
    cfgMode = m;
    cfgGate = g;
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic issueStart();
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
  endtask

  // Start, drive the scenario's pulses, and tally ticks until done rises.
  task automatic runGate();
    issueStart();
    ticksSeen = 0;
    fork
      begin
        waitClk(6);
        if (scen == 1) begin
          pulses(10);
          waitClk(6);
          inputOff = 1'b1;
          waitClk(4);
          pulses(7);
          waitClk(8);
          inputOff = 1'b0;
          waitClk(4);
          pulses(5);
        end else begin
          pulses(pulsesK);
          if (midSel >= 0) writeCfg(2'b00, 2'(midSel));
        end
      end
      begin
        while (!done) begin
          if (refTick) ticksSeen++;
          @(negedge clk);
        end
      end
    join
  endtask

  initial begin
    void'($urandom(32'd20240611));
    midSel = -1;
    scen = 0;
    waitClk(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(count == 20'd0, "R1 count after reset", int'(count), 0);

    // R1: default select is 00, so the window is 75 ticks
    pulsesK = 3;
    runGate();
    check(ticksSeen == 75, "R1 default gate ticks", ticksSeen, 75);
    check(count == 20'd3, "R5 count default gate", int'(count), 3);

    // R2 R4 R5: every gate select with a random pulse count
    for (int sel = 0; sel < 4; sel++) begin
      writeCfg(2'b00, 2'(sel));
      pulsesK = 1 + int'($urandom % 30);
      runGate();
      check(ticksSeen == gateTicks(sel), "R2 R4 gate ticks", ticksSeen, gateTicks(sel));
      check(int'(count) == pulsesK, "R5 edge count", int'(count), pulsesK);
    end

    // R3: saturation of the narrow instance, full width unaffected
    writeCfg(2'b00, 2'd3);
    pulsesK = 100;
    runGate();
    check(int'(count) == 100, "R3 wide count", int'(count), 100);
    check(int'(countS) == satVal(100, 6), "R3 narrow count saturates", int'(countS), 63);

    // R6: shut-out edges are not counted
    scen = 1;
    runGate();
    scen = 0;
    check(int'(count) == 15, "R6 inhibited edges", int'(count), 15);

    // R7: edges after done leave the result unchanged
    pulses(12);
    waitClk(5);
    check(int'(count) == 15, "R7 hold after done", int'(count), 15);
    check(done == 1'b1, "R7 flag held", int'(done), 1);

    // R8: start in a non-measurement mode is ignored
    writeCfg(2'b01, 2'd0);
    issueStart();
    pulses(6);
    waitClk(400);
    check(done == 1'b1, "R8 done unchanged", int'(done), 1);
    check(int'(count) == 15, "R8 count unchanged", int'(count), 15);

    // R9: a mid-window write does not change the current window
    writeCfg(2'b00, 2'd0);
    pulsesK = 4;
    midSel = 3;
    runGate();
    midSel = -1;
    check(ticksSeen == 75, "R9 current window kept", ticksSeen, 75);
    pulsesK = 2;
    runGate();
    check(ticksSeen == 2400, "R9 new select at next start", ticksSeen, 2400);

    // R10: a restart during an open window
    writeCfg(2'b00, 2'd1);
    issueStart();
    waitClk(20);
    pulses(5);
    waitClk(10);
    check(done == 1'b0, "R10 gate still open", int'(done), 0);
    pulsesK = 3;
    runGate();
    check(ticksSeen == 300, "R10 full window after restart", ticksSeen, 300);
    check(int'(count) == 3, "R10 count cleared by restart", int'(count), 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule